// File: doc/BRIEF.md
# CAS-before-RAS DRAM Refresh Controller

This block schedules refresh for a two-bank DRAM array using the CAS-before-RAS method. A slow real-time-clock crystal is sampled by the system clock. A 2-bit speed code selects how many crystal rising edges make one refresh request. Each request is held in a saturating pending counter until the normal-access controller grants the shared strobes. The block then runs a fixed strobe sequence on the system clock.

Per-bank configuration selects the strobes for the sequence: enable, 2-way interleave and an 8/16-bit width bit. The odd and even column strobes are shared by both banks. A line is driven when any enabled bank uses it and is tri-stated otherwise. A disabled bank has its row strobe tri-stated.

The request and grant pair is a plain level handshake and is not a data stream. The request stays high from the moment a refresh is pending until the precharge clock of the last queued cycle ends. Holding the grant low stalls refresh, and ticks that arrive meanwhile are counted in the pending counter.

Top module: `cbr_refresh_ctrl`

## Requirements
- R1: With speed code `cfg_ctrl[5:4]` of 00 or 01, every rising edge of `rtc_xtal` produces one refresh request.
- R2: Speed code 10 produces one request per 8 crystal rising edges, and code 11 produces one per 16.
- R3: A refresh cycle drives the selected column strobes low for one clock with row strobes high. It then holds row and column strobes low together for one clock. Next the column strobes go high while the row strobes stay low for one clock. A final clock with all strobes high gives the precharge.
- R4: A refresh cycle starts only in a clock where `ref_req` and `ref_gnt` are both high. `ref_req` is high while a refresh is pending or a cycle is running.
- R5: Requests not yet served are counted up to 15 (saturating) and are served back to back while the grant stays high.
- R6: Bank enables are `cfg_ctrl[3]` (bank 1) and `cfg_ctrl[2]` (bank 0). A disabled bank keeps `ras_oe` low and `ras_n` high, and its interleave and width settings select no strobe. With neither bank enabled, ticks are discarded and `ref_req` stays low.
- R7: An enabled, non-interleaved bank with `bank_wide[b]`=0 (8-bit) uses odd column line 0 only.
- R8: An enabled, non-interleaved bank with `bank_wide[b]`=1 (16-bit) uses odd column lines 1 and 0.
- R9: An enabled bank with its interleave bit set (`cfg_ctrl[1]` bank 1, `cfg_ctrl[0]` bank 0) uses odd lines 1:0 and even lines 1:0, whatever its width bit.
- R10: Each shared column line has its output enable high when any enabled bank uses it. A line no enabled bank uses keeps its enable low and its level high.
- R11: `dwr_n` stays high at all times, including every refresh cycle.
- R12: During reset, `ref_req` is low and all strobes are high. With all banks disabled, every output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_xtal | input | 1 | Real-time-clock crystal, asynchronous to clk |
| cfg_ctrl | input | 6 | Speed [5:4], bank 1 enable [3], bank 0 enable [2], bank 1 interleave [1], bank 0 interleave [0] |
| bank_wide | input | 2 | Per-bank width, 1 = 16-bit |
| ref_gnt | input | 1 | Grant of the shared strobes from the access controller |
| ref_req | output | 1 | Refresh request |
| ras_n | output | 2 | Row strobes, one per bank, active low |
| ras_oe | output | 2 | Row strobe output enables |
| cas_odd_n | output | 2 | Odd column strobes, active low |
| cas_odd_oe | output | 2 | Odd column strobe output enables |
| cas_even_n | output | 2 | Even column strobes, active low |
| cas_even_oe | output | 2 | Even column strobe output enables |
| dwr_n | output | 1 | DRAM write strobe, held inactive |

## Verification
The assertions check on every cycle that column strobes lead and trail the row strobes, that each cycle starts under a grant, and that the pending count neither wraps nor is popped when empty. They also check that a row strobe falls only for an enabled bank. Only the bench scenarios can show the request interval for each speed code and crystal rate, and the exact lane pattern for each enable, interleave and width mix. The scenarios also show how many requests are queued and drained after a stall, saturation at 15, and that ticks are discarded when no bank is enabled.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;
  localparam int NBANK = 2;
  localparam int NLANE = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAS,
    ST_RAS,
    ST_REL,
    ST_PRE
  } seq_state_e;
endpackage

// File: rtl/cbr_prescaler.sv
module cbr_prescaler #(
  parameter int DIV_LO = 8,
  parameter int DIV_HI = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal,
  input  logic [1:0] speed,
  output logic       tick
);
  localparam int CW = $clog2(DIV_HI);

  logic          sync1, sync2, sync3;
  logic          xedge;
  logic [CW-1:0] cnt, limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= xtal;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign xedge = sync2 & ~sync3;

  always_comb begin
    unique case (speed)
      2'b10:   limit = CW'(DIV_LO - 1);
      2'b11:   limit = CW'(DIV_HI - 1);
      default: limit = '0;
    endcase
  end

  assign tick = xedge && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (xedge) cnt <= (cnt >= limit) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/cbr_req_queue.sv
module cbr_req_queue #(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  output logic pending
);
  localparam logic [PEND_W-1:0] CNT_MAX = '1;

  logic [PEND_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (push && !pop) cnt <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    else if (!push && pop) cnt <= cnt - 1'b1;
  end

  assign pending = (cnt != '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == CNT_MAX) |-> (cnt >= CNT_MAX - 1'b1));

  // R5
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import cbr_refresh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic gnt,
  output logic pop,
  output logic req,
  output logic cas_on,
  output logic ras_on
);
  seq_state_e state, state_nx;

  assign pop = (state == ST_IDLE) && pending && gnt;

  always_comb begin
    unique case (state)
      ST_IDLE: state_nx = pop ? ST_CAS : ST_IDLE;
      ST_CAS:  state_nx = ST_RAS;
      ST_RAS:  state_nx = ST_REL;
      ST_REL:  state_nx = ST_PRE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign cas_on = (state == ST_CAS) || (state == ST_RAS);
  assign ras_on = (state == ST_RAS) || (state == ST_REL);
  assign req    = (state != ST_IDLE) || pending;

  // R3
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_on) |-> $past(cas_on) && cas_on);

  // R3
  cas_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_on) |-> ras_on);

  // R3
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_on) |=> !cas_on && !ras_on);

  // R4
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_on) |-> $past(gnt) && $past(req));
endmodule

// File: rtl/cbr_refresh_ctrl.sv
module cbr_refresh_ctrl
  import cbr_refresh_pkg::*;
#(
  parameter int DIV_LO = 8,
  parameter int DIV_HI = 16,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_xtal,
  input  logic [5:0]       cfg_ctrl,
  input  logic [NBANK-1:0] bank_wide,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic [NBANK-1:0] ras_n,
  output logic [NBANK-1:0] ras_oe,
  output logic [NLANE-1:0] cas_odd_n,
  output logic [NLANE-1:0] cas_odd_oe,
  output logic [NLANE-1:0] cas_even_n,
  output logic [NLANE-1:0] cas_even_oe,
  output logic             dwr_n
);
  logic [1:0]       speed;
  logic [NBANK-1:0] bank_en, bank_ilv;
  logic             tick, push, pop, pending, cas_on, ras_on;
  logic [NLANE-1:0] odd_use, even_use;

  assign speed    = cfg_ctrl[5:4];
  assign bank_en  = cfg_ctrl[3:2];
  assign bank_ilv = cfg_ctrl[1:0];

  cbr_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_presc (
    .clk(clk), .rst_n(rst_n), .xtal(rtc_xtal), .speed(speed), .tick(tick)
  );

  assign push = tick && (|bank_en);

  cbr_req_queue #(.PEND_W(PEND_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .pending(pending)
  );

  cbr_strobe_seq u_seq (
    .clk(clk), .rst_n(rst_n), .pending(pending), .gnt(ref_gnt),
    .pop(pop), .req(ref_req), .cas_on(cas_on), .ras_on(ras_on)
  );

  always_comb begin
    odd_use  = '0;
    even_use = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bank_en[b]) begin
        odd_use[0] = 1'b1;
        if (bank_ilv[b] || bank_wide[b]) odd_use[1] = 1'b1;
        if (bank_ilv[b])                 even_use    = '1;
      end
    end
  end

  assign ras_oe      = bank_en;
  assign cas_odd_oe  = odd_use;
  assign cas_even_oe = even_use;
  assign ras_n       = ~(bank_en  & {NBANK{ras_on}});
  assign cas_odd_n   = ~(odd_use  & {NLANE{cas_on}});
  assign cas_even_n  = ~(even_use & {NLANE{cas_on}});
  assign dwr_n       = 1'b1;

  // R6
  ras_bank0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n[0] |-> cfg_ctrl[2]);

  // R6
  ras_bank1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n[1] |-> cfg_ctrl[3]);
endmodule

// File: tb/cbr_refresh_ctrl_bench.sv
`timescale 1ns/1ps
module cbr_refresh_ctrl_bench;
  typedef struct packed {
    logic [7:0]  half;
    logic [5:0]  cfg;
    logic [1:0]  wide;
    logic [15:0] intv;
    logic [1:0]  ras;
    logic [1:0]  odd;
    logic [1:0]  even;
  } row_t;

  // half-period of crystal, cfg, width, expected interval, expected enables
  localparam int NROW = 7;
  localparam row_t TBL [NROW] = '{
    '{8'd8, 6'b00_0100, 2'b00, 16'd16,  2'b01, 2'b01, 2'b00},  // R1 R7
    '{8'd4, 6'b01_0100, 2'b01, 16'd8,   2'b01, 2'b11, 2'b00},  // R1 R8
    '{8'd8, 6'b10_1000, 2'b00, 16'd128, 2'b10, 2'b01, 2'b00},  // R2 R6
    '{8'd4, 6'b11_1010, 2'b00, 16'd128, 2'b10, 2'b11, 2'b11},  // R2 R9
    '{8'd8, 6'b00_1101, 2'b00, 16'd16,  2'b11, 2'b11, 2'b11},  // R9 R10
    '{8'd8, 6'b00_1100, 2'b10, 16'd16,  2'b11, 2'b11, 2'b00},  // R10
    '{8'd8, 6'b00_1001, 2'b11, 16'd16,  2'b10, 2'b11, 2'b00}   // R6
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rtc_free = 1'b0, rtc_man, rtc_run;
  logic       rtc_xtal;
  logic [5:0] cfg_ctrl;
  logic [1:0] bank_wide;
  logic       ref_gnt, ref_req, dwr_n;
  logic [1:0] ras_n, ras_oe, cas_odd_n, cas_odd_oe, cas_even_n, cas_even_oe;
  int         half;
  int         cyc = 0;
  int         errors = 0;
  int         checks = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign rtc_xtal = rtc_run ? rtc_free : rtc_man;

  initial begin
    int hc;
    hc = 0;
    forever begin
      @(negedge clk);
      if (hc >= half - 1) begin
        rtc_free = ~rtc_free;
        hc = 0;
      end else hc++;
    end
  end

  cbr_refresh_ctrl u_cbr_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .rtc_xtal(rtc_xtal), .cfg_ctrl(cfg_ctrl),
    .bank_wide(bank_wide), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ras_n(ras_n), .ras_oe(ras_oe), .cas_odd_n(cas_odd_n),
    .cas_odd_oe(cas_odd_oe), .cas_even_n(cas_even_n),
    .cas_even_oe(cas_even_oe), .dwr_n(dwr_n)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_xtal(input int n);
    for (int i = 0; i < n; i++) begin
      rtc_man = 1'b1;
      repeat (4) @(negedge clk);
      rtc_man = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic count_starts(input int ncyc, output int n, output logic saw_req);
    logic prv;
    n = 0;
    saw_req = 1'b0;
    prv = cas_odd_n[0];
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (prv && !cas_odd_n[0]) n++;
      if (ref_req) saw_req = 1'b1;
      prv = cas_odd_n[0];
    end
  endtask

  task automatic wait_start(output int t);
    logic prv;
    prv = cas_odd_n[0];
    forever begin
      @(negedge clk);
      if (prv && !cas_odd_n[0]) begin
        t = cyc;
        return;
      end
      prv = cas_odd_n[0];
    end
  endtask

  task automatic check_pattern(input row_t r);
    // CAS-only clock
    check(ras_n == 2'b11, "R3 ras high in cas clock", ras_n, 2'b11);
    check(cas_odd_n == ~r.odd, "R7/R8 odd pattern", cas_odd_n, ~r.odd);
    check(cas_even_n == ~r.even, "R9 even pattern", cas_even_n, ~r.even);
    check(ras_oe == r.ras, "R6 ras enables", ras_oe, r.ras);
    check(cas_odd_oe == r.odd, "R10 odd enables", cas_odd_oe, r.odd);
    check(cas_even_oe == r.even, "R10 even enables", cas_even_oe, r.even);
    check(dwr_n == 1'b1, "R11 write strobe high", dwr_n, 1);
    @(negedge clk);
    check(ras_n == ~r.ras, "R3 ras low in overlap clock", ras_n, ~r.ras);
    check(cas_odd_n == ~r.odd, "R3 cas held in overlap clock", cas_odd_n, ~r.odd);
    @(negedge clk);
    check(ras_n == ~r.ras, "R3 ras held after cas release", ras_n, ~r.ras);
    check({cas_odd_n, cas_even_n} == 4'hF, "R3 cas released first",
          {cas_odd_n, cas_even_n}, 4'hF);
    @(negedge clk);
    check({ras_n, cas_odd_n, cas_even_n} == 6'h3F, "R3 precharge clock",
          {ras_n, cas_odd_n, cas_even_n}, 6'h3F);
    check(dwr_n == 1'b1, "R11 write strobe high in precharge", dwr_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..R12 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n, t1, t2, t3;
    logic saw;
    rst_n = 1'b0; cfg_ctrl = '0; bank_wide = '0; ref_gnt = 1'b0;
    rtc_run = 1'b0; rtc_man = 1'b0; half = 8;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(ref_req == 1'b0, "R12 reset req", ref_req, 0);
    check({ras_n, cas_odd_n, cas_even_n} == 6'h3F, "R12 reset strobes",
          {ras_n, cas_odd_n, cas_even_n}, 6'h3F);
    check({ras_oe, cas_odd_oe, cas_even_oe} == 6'h0, "R12 reset enables",
          {ras_oe, cas_odd_oe, cas_even_oe}, 0);
    check(dwr_n == 1'b1, "R11 write strobe at reset", dwr_n, 1);
    rst_n = 1'b1;

    // R6: neither bank enabled, ticks are discarded
    ref_gnt = 1'b1;
    pulse_xtal(3);
    count_starts(40, n, saw);
    check(n == 0, "R6 no refresh with banks disabled", n, 0);
    check(saw == 1'b0, "R6 no request with banks disabled", saw, 0);

    // R4: stall under no grant, then R5 drain
    cfg_ctrl = 6'b00_0100;
    ref_gnt = 1'b0;
    pulse_xtal(3);
    count_starts(30, n, saw);
    check(n == 0, "R4 no cycle without grant", n, 0);
    check(ref_req == 1'b1, "R4 request held while pending", ref_req, 1);
    ref_gnt = 1'b1;
    count_starts(60, n, saw);
    check(n == 3, "R5 queued requests drained", n, 3);
    check(ref_req == 1'b0, "R4 request drops when drained", ref_req, 0);

    // R5: saturation at 15
    ref_gnt = 1'b0;
    pulse_xtal(20);
    ref_gnt = 1'b1;
    count_starts(150, n, saw);
    check(n == 15, "R5 pending count saturates", n, 15);

    // Table walk: interval and strobe pattern per configuration
    rtc_run = 1'b1;
    for (int i = 0; i < NROW; i++) begin
      cfg_ctrl  = TBL[i].cfg;
      bank_wide = TBL[i].wide;
      half      = int'(TBL[i].half);
      count_starts(20, n, saw);
      wait_start(t1);
      wait_start(t2);
      check_pattern(TBL[i]);
      wait_start(t3);
      check((t3 - t2) == int'(TBL[i].intv), "R1/R2 refresh interval",
            t3 - t2, TBL[i].intv);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule